// File: doc/BRIEF.md
# Cyclic (7,4) Codec with Syndrome Decision

This block pairs an encoder and a checker for a systematic cyclic code. The encoder takes a 4-bit data word, pads it on the right with three zeros and performs modulo-2 long division by a fixed 4-bit generator polynomial (default 1011). The three remainder bits follow the data word to form a 7-bit code word. The checker performs the same division on a received 7-bit word without padding. The remainder is the syndrome. An all-zero syndrome accepts the word and shows its leftmost four bits as data. Any other syndrome discards the word.

Each half has its own start/done handshake and runs one division step per clock. At every step the leading bit of the 4-bit working window decides what is XORed in: the generator when the bit is 1, all zeros when it is 0. The next dividend bit is then shifted in. A start is accepted only while its half is idle. The result appears four clocks after the accepting edge and stays on the outputs until the next accepted start.

Top module: `cyc_codec`

## Requirements
- R1: A synchronous active-high `rst` sets both halves to idle. After reset, `enc_busy`, `enc_done`, `chk_busy`, `chk_done`, `chk_accept` and `chk_discard` are all 0, and `enc_code`, `chk_syndrome` and `chk_data` are 0.
- R2: The encoder accepts a start on a rising edge while idle. `enc_done` is 1 for the cycle that follows the fourth rising edge after that one. `enc_code` then equals {data, remainder of data·x³ divided by the generator}: data in bits 6:3 and the check bits in bits 2:0.
- R3: Each division step XORs the generator into the window when the window's leading bit is 1, and XORs zero when it is 0. With generator 1011, data 1001 encodes to 1001110.
- R4: Each done is a single-cycle pulse. The code word, syndrome, accept, discard and data outputs hold their values from the done cycle until the next accepted start.
- R5: A start that arrives while a half is busy is ignored. The running division finishes on its own input, with the same timing.
- R6: The checker accepts a start on a rising edge while idle. `chk_done` pulses with the same timing as in R2. `chk_syndrome` equals the remainder of the 7-bit received word divided by the generator, with no padding.
- R7: When the syndrome is 000, `chk_accept` is 1, `chk_discard` is 0 and `chk_data` equals received bits 6:3.
- R8: When the syndrome is nonzero, `chk_discard` is 1, `chk_accept` is 0 and `chk_data` is 0000.
- R9: Every error-free code word of all 16 data words gives syndrome 000. Every single-bit corruption of any code word gives a nonzero syndrome.
- R10: Any valid code word rotated left by one position passes the checker with syndrome 000.
- R11: `chk_accept` and `chk_discard` are never 1 together. Both are 0 from an accepted start until that check's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enc_start | input | 1 | Start pulse for the encoder |
| enc_data | input | 4 | Data word, sampled with an accepted start |
| enc_busy | output | 1 | Encoder division in progress |
| enc_done | output | 1 | One-cycle pulse when the code word is ready |
| enc_code | output | 7 | Code word: data in 6:3, check bits in 2:0 |
| chk_start | input | 1 | Start pulse for the checker |
| chk_word | input | 7 | Received word, sampled with an accepted start |
| chk_busy | output | 1 | Checker division in progress |
| chk_done | output | 1 | One-cycle pulse when the syndrome is ready |
| chk_syndrome | output | 3 | Remainder of the received word |
| chk_accept | output | 1 | Syndrome is zero; data is shown |
| chk_discard | output | 1 | Syndrome is nonzero; word is rejected |
| chk_data | output | 4 | Received bits 6:3 when accepted, else 0 |

## Verification
A fault in the step counter shows at the ports within one run. `enc_done` or `chk_done` rises one cycle early or late, and `busy` does not fall on time. A fault in the window, the shift of remaining dividend bits, or the choice of subtrahend changes the check bits of at least one of the 16 data words. It also shows up as a false accept or a false discard among the corrupted and rotated words. Each fault appears in the done cycle of the affected run. A result register that is not held is seen on the first idle cycle after done.

// File: rtl/cyc_codec_pkg.sv
package cyc_codec_pkg;
    localparam int DEF_DATA_W = 4;
    localparam int DEF_GEN_W  = 4;
    localparam logic [DEF_GEN_W-1:0] DEF_GEN = 4'b1011;

    function automatic int code_width(input int data_w, input int gen_w);
        return data_w + gen_w - 1;
    endfunction
endpackage

// File: rtl/div_step.sv
module div_step #(
    parameter int GEN_W = 4,
    parameter logic [GEN_W-1:0] GEN = 4'b1011
) (
    input  logic [GEN_W-1:0] window_i,
    output logic [GEN_W-2:0] rem_o
);
    localparam int REM_W = GEN_W - 1;

    // leading bit selects generator or all-zero subtrahend
    logic lead;
    assign lead = window_i[GEN_W-1];

    for (genvar i = 0; i < REM_W; i++) begin : g_bit
        assign rem_o[i] = window_i[i] ^ (lead & GEN[i]);
    end
endmodule

// File: rtl/div_engine.sv
module div_engine #(
    parameter int DIV_W = 7,
    parameter int GEN_W = 4,
    parameter logic [GEN_W-1:0] GEN = 4'b1011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIV_W-1:0] dividend_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             valid_o,
    output logic [GEN_W-2:0] rem_o
);
    localparam int REM_W = GEN_W - 1;
    localparam int STEPS = DIV_W - REM_W;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [REM_W-1:0] acc;
        logic [STEPS-1:0] rest;
    } eng_t;

    eng_t st_q, st_d;
    logic [REM_W-1:0] step_rem;

    div_step #(.GEN_W(GEN_W), .GEN(GEN)) i_step (
        .window_i ({st_q.acc, st_q.rest[STEPS-1]}),
        .rem_o    (step_rem)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && start_i) begin
            st_d.busy  = 1'b1;
            st_d.valid = 1'b0;
            st_d.cnt   = '0;
            st_d.acc   = dividend_i[DIV_W-1 -: REM_W];
            st_d.rest  = dividend_i[STEPS-1:0];
        end else if (st_q.busy) begin
            st_d.acc  = step_rem;
            st_d.rest = st_q.rest << 1;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign valid_o = st_q.valid;
    assign rem_o   = st_q.acc;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!st_q.busy && !st_q.done && !st_q.valid));
    a_r2_done_follows_run: assert property (@(posedge clk) disable iff (rst)
        st_q.done |-> $past(st_q.busy));
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> !st_q.done);
    a_r11_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !(st_q.valid && st_q.busy));
    a_r5_busy_runs_on: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt != LAST) |=> st_q.busy);
endmodule

// File: rtl/cyc_encoder.sv
module cyc_encoder #(
    parameter int DATA_W = 4,
    parameter int GEN_W  = 4,
    parameter logic [GEN_W-1:0] GEN = 4'b1011
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [DATA_W-1:0]         data_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [DATA_W+GEN_W-2:0]   code_o
);
    localparam int REM_W  = GEN_W - 1;
    localparam int CODE_W = DATA_W + REM_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } enc_t;

    enc_t st_q, st_d;
    logic eng_busy, eng_valid;
    logic [REM_W-1:0] eng_rem;

    div_engine #(.DIV_W(CODE_W), .GEN_W(GEN_W), .GEN(GEN)) i_eng (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i ({data_i, {REM_W{1'b0}}}),
        .busy_o     (eng_busy),
        .done_o     (done_o),
        .valid_o    (eng_valid),
        .rem_o      (eng_rem)
    );

    always_comb begin
        st_d = st_q;
        if (start_i && !eng_busy) st_d.data = data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = eng_busy;
    assign code_o = {st_q.data, eng_rem};

    a_r5_data_locked: assert property (@(posedge clk) disable iff (rst)
        eng_busy |=> $stable(st_q.data));
    a_r4_code_held: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && !start_i) |=> $stable(code_o));
endmodule

// File: rtl/cyc_checker.sv
module cyc_checker #(
    parameter int DATA_W = 4,
    parameter int GEN_W  = 4,
    parameter logic [GEN_W-1:0] GEN = 4'b1011
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [DATA_W+GEN_W-2:0] word_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [GEN_W-2:0]        syndrome_o,
    output logic                    accept_o,
    output logic                    discard_o,
    output logic [DATA_W-1:0]       data_o
);
    localparam int REM_W  = GEN_W - 1;
    localparam int CODE_W = DATA_W + REM_W;

    typedef struct packed {
        logic [CODE_W-1:0] word;
    } chk_t;

    chk_t st_q, st_d;
    logic eng_busy, eng_valid, syn_zero;
    logic [REM_W-1:0] eng_rem;

    div_engine #(.DIV_W(CODE_W), .GEN_W(GEN_W), .GEN(GEN)) i_eng (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (word_i),
        .busy_o     (eng_busy),
        .done_o     (done_o),
        .valid_o    (eng_valid),
        .rem_o      (eng_rem)
    );

    always_comb begin
        st_d = st_q;
        if (start_i && !eng_busy) st_d.word = word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign syn_zero   = (eng_rem == '0);
    assign busy_o     = eng_busy;
    assign syndrome_o = eng_valid ? eng_rem : '0;
    assign accept_o   = eng_valid && syn_zero;
    assign discard_o  = eng_valid && !syn_zero;
    assign data_o     = accept_o ? st_q.word[CODE_W-1 -: DATA_W] : '0;

    a_r11_one_verdict: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && discard_o));
    a_r11_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> (!accept_o && !discard_o));
    a_r7_accept_shows_data: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (data_o == st_q.word[CODE_W-1 -: DATA_W] && syndrome_o == '0));
    a_r8_discard_blank: assert property (@(posedge clk) disable iff (rst)
        discard_o |-> (data_o == '0 && syndrome_o != '0));
endmodule

// File: rtl/cyc_codec.sv
module cyc_codec
    import cyc_codec_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int GEN_W  = DEF_GEN_W,
    parameter logic [GEN_W-1:0] GEN = DEF_GEN,
    localparam int CODE_W = code_width(DATA_W, GEN_W),
    localparam int REM_W  = GEN_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_start,
    input  logic [DATA_W-1:0] enc_data,
    output logic              enc_busy,
    output logic              enc_done,
    output logic [CODE_W-1:0] enc_code,
    input  logic              chk_start,
    input  logic [CODE_W-1:0] chk_word,
    output logic              chk_busy,
    output logic              chk_done,
    output logic [REM_W-1:0]  chk_syndrome,
    output logic              chk_accept,
    output logic              chk_discard,
    output logic [DATA_W-1:0] chk_data
);
    cyc_encoder #(.DATA_W(DATA_W), .GEN_W(GEN_W), .GEN(GEN)) i_enc (
        .clk     (clk),
        .rst     (rst),
        .start_i (enc_start),
        .data_i  (enc_data),
        .busy_o  (enc_busy),
        .done_o  (enc_done),
        .code_o  (enc_code)
    );

    cyc_checker #(.DATA_W(DATA_W), .GEN_W(GEN_W), .GEN(GEN)) i_chk (
        .clk        (clk),
        .rst        (rst),
        .start_i    (chk_start),
        .word_i     (chk_word),
        .busy_o     (chk_busy),
        .done_o     (chk_done),
        .syndrome_o (chk_syndrome),
        .accept_o   (chk_accept),
        .discard_o  (chk_discard),
        .data_o     (chk_data)
    );
endmodule

// File: tb/test_cyc_codec.sv
module test_cyc_codec;
    localparam logic [3:0] G = 4'b1011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_start = 1'b0;
    logic [3:0] enc_data = '0;
    logic enc_busy, enc_done;
    logic [6:0] enc_code;
    logic chk_start = 1'b0;
    logic [6:0] chk_word = '0;
    logic chk_busy, chk_done, chk_accept, chk_discard;
    logic [2:0] chk_syndrome;
    logic [3:0] chk_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cyc_codec i_cyc_codec (
        .clk(clk), .rst(rst),
        .enc_start(enc_start), .enc_data(enc_data), .enc_busy(enc_busy),
        .enc_done(enc_done), .enc_code(enc_code),
        .chk_start(chk_start), .chk_word(chk_word), .chk_busy(chk_busy),
        .chk_done(chk_done), .chk_syndrome(chk_syndrome),
        .chk_accept(chk_accept), .chk_discard(chk_discard), .chk_data(chk_data)
    );

    // polynomial remainder computed on integers
    function automatic logic [2:0] pmod(input logic [6:0] w);
        int v = int'(w);
        for (int i = 6; i >= 3; i--)
            if (v[i]) v = v ^ (int'(G) << (i - 3));
        return v[2:0];
    endfunction

    function automatic logic [6:0] encode(input logic [3:0] d);
        return {d, pmod({d, 3'b000})};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-level reference model
    bit m_eb, m_ed, m_ev;  int m_ec;  logic [3:0] m_ew;
    bit m_cb, m_cd, m_cv;  int m_cc;  logic [6:0] m_cw;

    always @(posedge clk) begin
        if (rst) begin
            m_eb <= 0; m_ed <= 0; m_ev <= 0; m_ec <= 0; m_ew <= '0;
            m_cb <= 0; m_cd <= 0; m_cv <= 0; m_cc <= 0; m_cw <= '0;
        end else begin
            m_ed <= 0;
            if (!m_eb && enc_start) begin
                m_eb <= 1; m_ec <= 0; m_ev <= 0; m_ew <= enc_data;
            end else if (m_eb) begin
                m_ec <= m_ec + 1;
                if (m_ec == 3) begin m_eb <= 0; m_ed <= 1; m_ev <= 1; end
            end
            m_cd <= 0;
            if (!m_cb && chk_start) begin
                m_cb <= 1; m_cc <= 0; m_cv <= 0; m_cw <= chk_word;
            end else if (m_cb) begin
                m_cc <= m_cc + 1;
                if (m_cc == 3) begin m_cb <= 0; m_cd <= 1; m_cv <= 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [2:0] s;
            s = pmod(m_cw);
            check(enc_busy == m_eb, "R5 enc_busy", enc_busy, m_eb);
            check(enc_done == m_ed, "R2 enc_done", enc_done, m_ed);
            if (m_ev) check(enc_code == encode(m_ew), "R4 enc_code", enc_code, encode(m_ew));
            check(chk_busy == m_cb, "R5 chk_busy", chk_busy, m_cb);
            check(chk_done == m_cd, "R6 chk_done", chk_done, m_cd);
            check(chk_accept == (m_cv && s == 0), "R11 chk_accept", chk_accept, m_cv && s == 0);
            check(chk_discard == (m_cv && s != 0), "R11 chk_discard", chk_discard, m_cv && s != 0);
            if (m_cv) begin
                check(chk_syndrome == s, "R6 chk_syndrome", chk_syndrome, s);
                check(chk_data == ((s == 0) ? m_cw[6:3] : 4'h0), "R8 chk_data",
                      chk_data, (s == 0) ? m_cw[6:3] : 4'h0);
            end
        end
    end

    task automatic run_enc(input logic [3:0] d);
        @(negedge clk); enc_start = 1; enc_data = d;
        @(negedge clk); enc_start = 0;
        repeat (3) @(negedge clk);
        check(enc_done == 0, "R2 done early", enc_done, 0);
        @(negedge clk);
        check(enc_done == 1, "R2 done timing", enc_done, 1);
        check(enc_code == encode(d), "R2 code word", enc_code, encode(d));
    endtask

    task automatic run_chk(input logic [6:0] w, input bit exp_ok, input string tag);
        @(negedge clk); chk_start = 1; chk_word = w;
        @(negedge clk); chk_start = 0;
        repeat (4) @(negedge clk);
        check(chk_done == 1, "R6 done timing", chk_done, 1);
        check(chk_accept == exp_ok, tag, chk_accept, exp_ok);
        check(chk_discard == !exp_ok, tag, chk_discard, !exp_ok);
        if (exp_ok) check(chk_data == w[6:3], "R7 data shown", chk_data, w[6:3]);
        else        check(chk_data == 4'h0, "R8 data blanked", chk_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!enc_busy && !enc_done && enc_code == 0, "R1 encoder idle", enc_code, 0);
        check(!chk_busy && !chk_done && !chk_accept && !chk_discard, "R1 checker idle",
              {chk_busy, chk_done, chk_accept, chk_discard}, 0);
        check(chk_syndrome == 0 && chk_data == 0, "R1 outputs zero", chk_data, 0);
        rst = 0;

        // R3 hand-worked example
        run_enc(4'b1001);
        check(enc_code == 7'b1001110, "R3 long division", enc_code, 7'b1001110);
        // R4 hold after done
        repeat (3) @(negedge clk);
        check(!enc_done && enc_code == 7'b1001110, "R4 hold", enc_code, 7'b1001110);

        // R2 all data words
        for (int d = 0; d < 16; d++) run_enc(4'(d));

        // R5 start while busy ignored
        @(negedge clk); enc_start = 1; enc_data = 4'h5;
        @(negedge clk); enc_data = 4'hA;
        @(negedge clk); enc_start = 0;
        repeat (3) @(negedge clk);
        check(enc_done == 1, "R5 timing kept", enc_done, 1);
        check(enc_code == encode(4'h5), "R5 first input kept", enc_code, encode(4'h5));

        // R7, R9, R10 on the checker
        for (int d = 0; d < 16; d++) begin
            logic [6:0] cw;
            cw = encode(4'(d));
            run_chk(cw, 1'b1, "R9 clean word accepted");
            for (int b = 0; b < 7; b++)
                run_chk(cw ^ (7'd1 << b), 1'b0, "R9 single error discarded");
            run_chk({cw[5:0], cw[6]}, 1'b1, "R10 rotated accepted");
        end

        // R5 on checker: second start while busy dropped
        @(negedge clk); chk_start = 1; chk_word = encode(4'h3);
        @(negedge clk); chk_word = 7'b0000001;
        @(negedge clk); chk_start = 0;
        repeat (3) @(negedge clk);
        check(chk_accept == 1 && chk_data == 4'h3, "R5 checker input kept", chk_data, 3);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule